// File: doc/BRIEF.md
# Packed BCD String Comparator

This block compares two unsigned decimal numbers held in memory as packed BCD. It subtracts the source number from the destination number one digit at a time and keeps no copy of the difference. When it has finished it reports three flags: zero, carry (borrow) and overflow. A single start pulse supplies both base addresses and the length in digits. The block then reads one byte of each string per step through a synchronous read port whose data returns one cycle after the address. It never writes memory.

Each byte holds two digits. The low nibble is the less significant digit, and the byte at the lower address is the less significant byte. For an odd length, only the low nibble of the last byte is used. The base addresses and the length are captured when the operation starts, so the caller's values are never altered.

Top module: `bcd_strcmp`

## Requirements
- R1: The block reads only the bytes at dst_base+i and src_base+i, for i from 0 to ceil(cnt/2)-1. It has no write path.
- R2: Digit k of a string (k=0 least significant) is in byte k/2: in bits 3:0 when k is even and in bits 7:4 when k is odd.
- R3: At completion, cf is 1 exactly when the destination number is less than the source number, both taken as unsigned cnt-digit decimals. This is the borrow out of the most significant digit step.
- R4: At completion, zf is 1 exactly when every digit of the difference is 0. When zf is 1, cf and of are 0.
- R5: Let r be the most significant digit of the cnt-digit ten's-complement difference, and let d and s be the most significant destination and source digits. A digit counts as negative when it is 5 or more. At completion, of is 1 exactly when d and s differ in sign and r differs in sign from d.
- R6: For an odd cnt, the high nibble of the last byte of each string does not affect any flag.
- R7: When cnt is 0, done pulses in the cycle after start, with zf=1, cf=0 and of=0, and no memory read is made.
- R8: done is high for exactly one cycle. zf, cf and of change only in that cycle and hold their values until the next operation completes.
- R9: A start that arrives while an operation is in progress, or in its done cycle, is ignored. Changes to dst_base, src_base and cnt after the accepted start have no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a comparison (accepted when idle) |
| dst_base | input | ADDR_W | Address of the least significant byte of the destination number |
| src_base | input | ADDR_W | Address of the least significant byte of the source number |
| cnt | input | LEN_W | Length of both numbers in digits |
| mem_rd | output | 1 | Read strobe for the byte memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Difference is zero |
| cf | output | 1 | Final borrow (destination below source) |
| of | output | 1 | Signed ten's-complement overflow from the top digit step |

## Verification
The bench tries every pair of one-digit and every pair of two-digit numbers. This covers each borrow chain across a nibble boundary and each sign combination that decides the overflow flag. It then uses random pairs of three to eight digits, plus directed equal, all-nines and all-zeros pairs for long lengths. The odd lengths put a random digit in the unused nibble, which separates correct nibble selection from reading the whole byte. A zero length, a second start issued mid-operation with different operands, and a hold check after done separate correct start capture and flag retention from designs that re-sample their inputs or clear the flags early. Every memory read is checked against the address window of the accepted operation.

// File: rtl/bcd_strcmp.sv
module bcd_strcmp #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [LEN_W-1:0]  cnt,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              zf,
  output logic              cf,
  output logic              of
);

  typedef enum logic [2:0] {S_IDLE, S_RDD, S_RDS, S_CALC, S_FIN} st_t;

  st_t               st;
  logic [ADDR_W-1:0] dq, sq, idx;
  logic [LEN_W-1:0]  left;
  logic              brw, zacc;
  logic [7:0]        dbyte;

  function automatic logic [4:0] dstep(input logic [3:0] a, input logic [3:0] b, input logic bi);
    logic [4:0] t;
    t = {1'b0, a} - {1'b0, b} - {4'b0, bi};
    if (t[4]) return {1'b1, t[3:0] + 4'd10};
    return {1'b0, t[3:0]};
  endfunction

  logic [4:0] lo, hi;
  logic       two, last, bfin, znext;
  logic [3:0] md, ms, mr;

  assign lo    = dstep(dbyte[3:0], mem_rdata[3:0], brw);
  assign hi    = dstep(dbyte[7:4], mem_rdata[7:4], lo[4]);
  assign two   = left > LEN_W'(1);
  assign last  = left <= LEN_W'(2);
  assign bfin  = two ? hi[4] : lo[4];
  assign znext = zacc | (|lo[3:0]) | (two & (|hi[3:0]));
  assign md    = two ? dbyte[7:4]     : dbyte[3:0];
  assign ms    = two ? mem_rdata[7:4] : mem_rdata[3:0];
  assign mr    = two ? hi[3:0]        : lo[3:0];

  assign mem_rd   = (st == S_RDD) || (st == S_RDS);
  assign mem_addr = (st == S_RDS) ? sq + idx : dq + idx;
  assign done     = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      dq    <= '0;
      sq    <= '0;
      idx   <= '0;
      left  <= '0;
      brw   <= 1'b0;
      zacc  <= 1'b0;
      dbyte <= '0;
      zf    <= 1'b0;
      cf    <= 1'b0;
      of    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dq   <= dst_base;
          sq   <= src_base;
          left <= cnt;
          idx  <= '0;
          brw  <= 1'b0;
          zacc <= 1'b0;
          if (cnt == '0) begin
            zf <= 1'b1;
            cf <= 1'b0;
            of <= 1'b0;
            st <= S_FIN;
          end else begin
            st <= S_RDD;
          end
        end
        S_RDD: st <= S_RDS;
        S_RDS: begin
          dbyte <= mem_rdata;
          st    <= S_CALC;
        end
        S_CALC: begin
          brw  <= bfin;
          zacc <= znext;
          if (last) begin
            zf <= ~znext;
            cf <= bfin;
            of <= ((md >= 4'd5) != (ms >= 4'd5)) && ((mr >= 4'd5) != (md >= 4'd5));
            st <= S_FIN;
          end else begin
            left <= left - LEN_W'(2);
            idx  <= idx + ADDR_W'(1);
            st   <= S_RDD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({zf, cf, of}));

  a_r4_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zf) |-> (!cf && !of));

  a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && cnt == '0) |=> (done && zf && !cf && !of));

  a_r1_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDS) |=> $stable(dq) && $stable(sq));

endmodule

// File: tb/tb_bcd_strcmp.sv
module tb_bcd_strcmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dst_base = '0, src_base = '0;
  logic [7:0]  cnt = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done, zf, cf, of;

  bcd_strcmp dut (.*);

  always #4 clk = ~clk;

  logic [7:0] mem [256];
  int vecs = 0, bad = 0, nreads = 0;
  int exp_db = 0, exp_sb = 0, exp_nb = 0;

  always @(posedge clk) if (mem_rd) begin
    nreads <= nreads + 1;
    mem_rdata <= mem[mem_addr[7:0]];
    if (!((int'(mem_addr) >= exp_db && int'(mem_addr) < exp_db + exp_nb) ||
          (int'(mem_addr) >= exp_sb && int'(mem_addr) < exp_sb + exp_nb))) begin
      bad <= bad + 1;
      $display("FAIL R1: read addr %0d outside windows dst %0d src %0d bytes %0d",
               mem_addr, exp_db, exp_sb, exp_nb);
    end
  end

  function automatic longint p10(int n);
    longint p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

  function automatic int dig(longint v, int k);
    return int'((v / p10(k)) % 10);
  endfunction

  task automatic put(int base, int n, longint v);
    for (int j = 0; j < (n + 1) / 2; j++) begin
      int h;
      h = (2 * j + 1 < n) ? dig(v, 2 * j + 1) : int'($urandom_range(0, 9));
      mem[base + j] = 8'((h << 4) | dig(v, 2 * j));
    end
  endtask

  task automatic chk(string r, logic act, logic expv, string what);
    vecs++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: %s actual %0b expected %0b", r, what, act, expv);
    end
  endtask

  task automatic pulse(int db, int sb, int n);
    @(negedge clk);
    dst_base = 16'(db); src_base = 16'(sb); cnt = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic run(int n, longint d, longint s, int db, int sb);
    longint p, r;
    int w, md, ms, mr;
    logic ecf, ezf, eof;
    p = p10(n);
    r = (d - s + p) % p;
    ecf = d < s;
    ezf = d == s;
    md = n ? dig(d, n - 1) : 0;
    ms = n ? dig(s, n - 1) : 0;
    mr = n ? dig(r, n - 1) : 0;
    eof = n ? (((md >= 5) != (ms >= 5)) && ((mr >= 5) != (md >= 5))) : 1'b0;
    put(db, n, d);
    put(sb, n, s);
    exp_db = db; exp_sb = sb; exp_nb = (n + 1) / 2;
    pulse(db, sb, n);
    wait_done(w);
    chk("R8", done, 1'b1, "done seen");
    chk("R3", cf, ecf, $sformatf("cf n=%0d %0d-%0d", n, d, s));
    chk("R4", zf, ezf, $sformatf("zf n=%0d %0d-%0d", n, d, s));
    chk("R5", of, eof, $sformatf("of n=%0d %0d-%0d", n, d, s));
    @(negedge clk);
    chk("R8", done, 1'b0, "done low after pulse");
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int w;
    logic hz, hc, ho;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R8", done, 1'b0, "reset done");
    chk("R4", zf, 1'b0, "reset zf");
    rst_n = 1'b1;

    // R7: zero length
    exp_db = 0; exp_sb = 0; exp_nb = 0;
    nreads = 0;
    pulse(40, 80, 0);
    chk("R7", done, 1'b1, "done one cycle after start");
    chk("R7", zf, 1'b1, "zf empty");
    chk("R7", cf, 1'b0, "cf empty");
    chk("R7", of, 1'b0, "of empty");
    @(negedge clk);
    vecs++;
    if (nreads != 0) begin bad++; $display("FAIL R7: reads actual %0d expected 0", nreads); end

    // R2 R6: exhaustive one and two digit sweeps (odd n puts noise in unused nibble)
    for (int d = 0; d < 10; d++) for (int s = 0; s < 10; s++) run(1, d, s, 16, 96);
    for (int d = 0; d < 100; d++) for (int s = 0; s < 100; s++) run(2, d, s, 20, 100);

    // longer lengths
    for (int k = 0; k < 300; k++) begin
      int n;
      longint d, s;
      n = int'($urandom_range(3, 8));
      d = longint'($urandom) % p10(n);
      s = (k % 5 == 0) ? d : longint'($urandom) % p10(n);
      run(n, d, s, 30, 110);
    end
    run(8, 99999999, 0, 10, 60);
    run(8, 0, 99999999, 10, 60);
    run(7, 1234567, 1234567, 11, 61);
    run(8, 50000000, 49999999, 12, 62);

    // R8: flags hold after done
    run(3, 12, 345, 5, 50);
    hz = zf; hc = cf; ho = of;
    repeat (6) @(negedge clk);
    chk("R8", zf, hz, "zf held");
    chk("R8", cf, hc, "cf held");
    chk("R8", of, ho, "of held");

    // R9: second start and input changes while busy are ignored
    put(70, 4, 1000); put(120, 4, 2);
    put(140, 2, 5);   put(150, 2, 5);
    exp_db = 70; exp_sb = 120; exp_nb = 2;
    pulse(70, 120, 4);
    dst_base = 16'd140; src_base = 16'd150; cnt = 8'd2;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(w);
    chk("R9", zf, 1'b0, "zf of first operation");
    chk("R9", cf, 1'b0, "cf of first operation");
    chk("R9", of, 1'b0, "of of first operation");
    @(negedge clk);
    chk("R9", done, 1'b0, "no second operation");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule